// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a watchdog timer for a chip's always-on domain. Software arms it through a four-word register window: a strobe for writes, a strobe for reads, a 2-bit word index and 32-bit data. Once armed, a counter advances every clock. If software does not service the watchdog before the count reaches a power-of-two limit, the block raises a reset request. Software services the watchdog with two fixed key words, written to two registers in order. A wrong word, or a second key that does not follow a first key, is treated as a fault and also raises a reset request.

The reset request can also come from two other places: a software write to a soft-reset register, or a dedicated user-reset input pin. Every reset request is a registered pulse of fixed length. A 3-bit cause code records why the last request was raised. Only the external hard-reset input clears this code, so software can read it after the system comes back.

The service logic is a state machine with three states:
- `ST_EXPECT1` waits for the first key.
- `ST_EXPECT2` holds the first key and waits for the second.
- `ST_PULSE` drives the reset request.

Its transitions are:
- ARM_KEY: `ST_EXPECT1` to `ST_EXPECT2` when the first key is written correctly.
- SERVICE: `ST_EXPECT2` to `ST_EXPECT1` when the second key is written correctly.
- FIRE: either expect state to `ST_PULSE` on a timeout, soft reset, user reset or service fault.
- RELEASE: `ST_PULSE` to `ST_EXPECT1` after the pulse length has elapsed.

Top module: `keyed_watchdog`

## Requirements
- R1: After the hard reset, `rst_req` is 0, the configuration word reads 0 (disarmed, delay 0) and the cause field reads 0 (hard reset).
- R2: Word index 1 is configuration. Bit 31 is the enable bit and bits 4:0 are the delay `d`; all other bits read 0. Word index 2 reads the cause code in bits 2:0 with the upper bits 0. Reads of word indices 0 and 3 return 0. With `bus_rd` low, `bus_rdata` is 0.
- R3: While armed, `rst_req` rises exactly 2^(d+1) cycles after the write edge that armed the block or that completed the last valid service, and the cause becomes 1 (timeout).
- R4: A valid service is 0xABCD1234 written to word 2, followed by 0x4321DCBA written to word 3. It restarts the count from zero. Configuration writes between the two keys do not break the sequence.
- R5: Any of the following raises `rst_req` on the write edge and sets the cause to 2 (bad service), whether or not the block is armed:
  - a wrong word written to word 2;
  - a wrong word written to word 3;
  - a write to word 3 while no first key is held.
- R6: Writing exactly 1 to word 0 raises `rst_req` and sets the cause to 3 (soft reset). Any other value written there has no effect.
- R7: A high cycle on `user_rst` raises `rst_req` on that edge and sets the cause to 4 (user reset).
- R8: `rst_req` stays high for exactly 4 cycles. While it is high, all bus writes and `user_rst` are ignored. Afterwards the configuration is kept, no first key is held, and the count restarts from zero.
- R9: Clearing the enable bit does not stop the count. The block disarms only at the next valid service, and after that no timeout occurs.
- R10: The cause code changes only when a reset request starts, survives the block's own requests, and returns to 0 only on the hard reset.
- R11: If several triggers occur in one cycle, timeout wins over bus-triggered causes (soft reset or bad service), and those win over the user reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| hard_rst_n | input | 1 | Asynchronous active-low hard reset, clears everything including the cause |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe, read data is combinational |
| bus_widx | input | 2 | Word index: 0 soft reset, 1 config, 2 first key / cause, 3 second key |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, 0 when `bus_rd` is low |
| user_rst | input | 1 | User reset request, sampled each cycle |
| rst_req | output | 1 | Registered reset request pulse |

## Verification
A wrong held-key state shows up one write later. A valid second key then faults with cause 2, or a bad sequence is accepted silently, which the next timeout measurement exposes. A counter that is off by one, or a limit that is decoded wrongly, moves the `rst_req` edge away from 2^(d+1) cycles. This is visible within 64 cycles for the delays used. A wrong disarm or pulse-length state appears either as a request that should not come or as a request of the wrong width, within one timeout window.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
    localparam logic [31:0] KEY_FIRST  = 32'hABCD_1234;
    localparam logic [31:0] KEY_SECOND = 32'h4321_DCBA;
    localparam int          PULSE_LEN  = 4;
    localparam int          PCNT_W     = $clog2(PULSE_LEN);

    localparam logic [1:0] IDX_SOFT = 2'd0;
    localparam logic [1:0] IDX_CFG  = 2'd1;
    localparam logic [1:0] IDX_KEY1 = 2'd2;
    localparam logic [1:0] IDX_KEY2 = 2'd3;

    typedef enum logic [1:0] {
        ST_EXPECT1 = 2'd0,
        ST_EXPECT2 = 2'd1,
        ST_PULSE   = 2'd2
    } svc_state_e;

    typedef enum logic [2:0] {
        CAUSE_HARD    = 3'd0,
        CAUSE_TIMEOUT = 3'd1,
        CAUSE_BADSVC  = 3'd2,
        CAUSE_SOFT    = 3'd3,
        CAUSE_USER    = 3'd4
    } cause_e;
endpackage

// File: rtl/wdk_count.sv
module wdk_count #(
    parameter int DLY_W = 5,
    parameter int CNT_W = (1 << DLY_W) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic [DLY_W-1:0] dly,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim_m1;
    logic [DLY_W:0]   shamt;

    always_comb begin
        shamt   = {1'b0, dly} + (DLY_W+1)'(1);
        lim_m1  = (CNT_W'(1) << shamt) - CNT_W'(1);
        expired = run && (cnt_q >= lim_m1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt_q <= '0;
        else if (clr) cnt_q <= '0;
        else if (run) cnt_q <= cnt_q + CNT_W'(1);
    end

    AST_HOLD_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clr) |=> $stable(cnt_q)); // R9
endmodule

// File: rtl/wdk_regs.sv
module wdk_regs import wdk_pkg::*; #(
    parameter int DLY_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [1:0]       widx,
    input  logic             wen_bit,
    input  logic [DLY_W-1:0] wdly,
    input  logic             lock,
    input  logic             svc_ok,
    input  logic [2:0]       cause,
    output logic [DLY_W-1:0] cfg_dly,
    output logic             armed,
    output logic [31:0]      rdata
);
    logic cfg_en_q;
    logic armed_q;
    logic cfg_wr;

    assign cfg_wr  = wr_en && !lock && (widx == IDX_CFG);
    assign armed   = armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_en_q <= 1'b0;
            cfg_dly  <= '0;
            armed_q  <= 1'b0;
        end else begin
            if (cfg_wr) begin
                cfg_en_q <= wen_bit;
                cfg_dly  <= wdly;
            end
            if (cfg_wr && wen_bit) armed_q <= 1'b1;
            else if (svc_ok)       armed_q <= cfg_en_q;
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (widx)
                IDX_CFG: begin
                    rdata[31]          = cfg_en_q;
                    rdata[DLY_W-1:0]   = cfg_dly;
                end
                IDX_KEY1: rdata[2:0] = cause;
                default:  rdata      = '0;
            endcase
        end
    end

    AST_STOP_NEEDS_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !svc_ok) |=> armed_q); // R9
endmodule

// File: rtl/wdk_svc_fsm.sv
module wdk_svc_fsm import wdk_pkg::*; (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [1:0]  widx,
    input  logic [31:0] wdata,
    input  logic        user_req,
    input  logic        expired,
    output logic        svc_ok,
    output logic        pulse,
    output logic [2:0]  cause
);
    svc_state_e        state_q, state_d;
    cause_e            cause_q, cause_d;
    logic [PCNT_W-1:0] pcnt_q;
    logic              fire;
    logic              soft_hit, w_key1, w_key2;

    assign soft_hit = wr_en && (widx == IDX_SOFT) && (wdata == 32'd1);
    assign w_key1   = wr_en && (widx == IDX_KEY1);
    assign w_key2   = wr_en && (widx == IDX_KEY2);

    // next state: ARM_KEY, SERVICE, FIRE, RELEASE
    always_comb begin
        state_d = state_q;
        cause_d = cause_q;
        fire    = 1'b0;
        svc_ok  = 1'b0;
        unique case (state_q)
            ST_PULSE: begin
                if (pcnt_q == PCNT_W'(PULSE_LEN-1)) state_d = ST_EXPECT1;
            end
            ST_EXPECT1, ST_EXPECT2: begin
                if (expired) begin
                    fire = 1'b1; cause_d = CAUSE_TIMEOUT;
                end else if (soft_hit) begin
                    fire = 1'b1; cause_d = CAUSE_SOFT;
                end else if (w_key1 && wdata != KEY_FIRST) begin
                    fire = 1'b1; cause_d = CAUSE_BADSVC;
                end else if (w_key2 && (state_q != ST_EXPECT2 || wdata != KEY_SECOND)) begin
                    fire = 1'b1; cause_d = CAUSE_BADSVC;
                end else if (user_req) begin
                    fire = 1'b1; cause_d = CAUSE_USER;
                end else if (w_key1) begin
                    state_d = ST_EXPECT2;
                end else if (w_key2) begin
                    state_d = ST_EXPECT1;
                    svc_ok  = 1'b1;
                end
                if (fire) state_d = ST_PULSE;
            end
            default: state_d = ST_EXPECT1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EXPECT1;
            cause_q <= CAUSE_HARD;
            pcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            cause_q <= cause_d;
            if (state_q == ST_PULSE) pcnt_q <= pcnt_q + PCNT_W'(1);
            else                     pcnt_q <= '0;
        end
    end

    always_comb begin
        pulse = (state_q == ST_PULSE);
        cause = cause_q;
    end

    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pulse) |-> ($past(pulse, 1) && $past(pulse, 4))); // R8
    AST_NO_SERVICE_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> !svc_ok); // R8
    AST_CAUSE_ONLY_ON_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (cause_q != $past(cause_q)) |-> (pulse && !$past(pulse))); // R10
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog import wdk_pkg::*; #(
    parameter int DLY_W = 5
) (
    input  logic        clk,
    input  logic        hard_rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [1:0]  bus_widx,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        user_rst,
    output logic        rst_req
);
    localparam int CNT_W = (1 << DLY_W) + 1;

    logic             svc_ok, pulse, expired, armed;
    logic [2:0]       cause;
    logic [DLY_W-1:0] cfg_dly;

    wdk_svc_fsm u_fsm (
        .clk      (clk),
        .rst_n    (hard_rst_n),
        .wr_en    (bus_wr),
        .widx     (bus_widx),
        .wdata    (bus_wdata),
        .user_req (user_rst),
        .expired  (expired),
        .svc_ok   (svc_ok),
        .pulse    (pulse),
        .cause    (cause)
    );

    wdk_regs #(.DLY_W(DLY_W)) u_regs (
        .clk     (clk),
        .rst_n   (hard_rst_n),
        .wr_en   (bus_wr),
        .rd_en   (bus_rd),
        .widx    (bus_widx),
        .wen_bit (bus_wdata[31]),
        .wdly    (bus_wdata[DLY_W-1:0]),
        .lock    (pulse),
        .svc_ok  (svc_ok),
        .cause   (cause),
        .cfg_dly (cfg_dly),
        .armed   (armed),
        .rdata   (bus_rdata)
    );

    wdk_count #(.DLY_W(DLY_W), .CNT_W(CNT_W)) u_count (
        .clk     (clk),
        .rst_n   (hard_rst_n),
        .run     (armed && !pulse),
        .clr     (svc_ok || pulse),
        .dly     (cfg_dly),
        .expired (expired)
    );

    assign rst_req = pulse;

    AST_REQ_STARTS_CLEAN: assert property (@(posedge clk) disable iff (!hard_rst_n)
        $rose(rst_req) |-> !$past(svc_ok)); // R4
endmodule

// File: tb/keyed_watchdog_tb.sv
`timescale 1ns/1ps
module keyed_watchdog_tb;
    localparam logic [31:0] K1 = 32'hABCD_1234;
    localparam logic [31:0] K2 = 32'h4321_DCBA;

    logic        clk = 1'b0;
    logic        hard_rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0, user_rst = 1'b0;
    logic [1:0]  bus_widx = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rst_req;
    int          n_chk = 0, n_err = 0;

    always #2 clk = ~clk;

    keyed_watchdog u_dut (
        .clk(clk), .hard_rst_n(hard_rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_widx(bus_widx), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .user_rst(user_rst), .rst_req(rst_req)
    );

    function automatic int lim_of(input int d);
        return 1 << (d + 1);
    endfunction

    function automatic logic [31:0] cfg_word(input bit en, input int d);
        return {en, 26'd0, 5'(d)};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] idx, input logic [31:0] d);
        bus_wr = 1'b1; bus_widx = idx; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] idx, output logic [31:0] v);
        bus_rd = 1'b1; bus_widx = idx;
        #0.5;
        v = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic hard_reset();
        bus_wr = 0; bus_rd = 0; user_rst = 0;
        hard_rst_n = 1'b0;
        idle(3);
        hard_rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic measure(output int n);
        n = 0;
        while (!rst_req && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic wait_end();
        while (rst_req) @(negedge clk);
    endtask

    task automatic service();
        wr(2'd2, K1);
        wr(2'd3, K2);
    endtask

    task automatic expect_cause(input string req, input logic [2:0] c);
        logic [31:0] v;
        rd(2'd2, v);
        chk(req, v, {29'd0, c});
    endtask

    initial begin
        #400000;
        n_err++;
        $display("FAIL watchdog expired actual=hang expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int n, d, g, act;
        bit quiet;
        void'($urandom(32'd1357));

        @(negedge clk);
        hard_reset();
        // R1 reset state
        chk("R1 rst_req", {31'd0, rst_req}, 32'd0);
        rd(2'd1, v); chk("R1 config", v, 32'd0);
        expect_cause("R1 cause", 3'd0);

        // R2 register map and readback
        wr(2'd1, 32'h7FF0_0013);
        rd(2'd1, v); chk("R2 config readback", v, 32'h0000_0013);
        rd(2'd0, v); chk("R2 word0 read", v, 32'd0);
        rd(2'd3, v); chk("R2 word3 read", v, 32'd0);
        bus_widx = 2'd1; #0.5; chk("R2 idle rdata", bus_rdata, 32'd0);

        // R3 timeout per delay, R8 pulse width
        for (int dd = 0; dd < 5; dd++) begin
            hard_reset();
            wr(2'd1, cfg_word(1, dd));
            measure(n);
            chk("R3 timeout cycles", n, lim_of(dd));
            expect_cause("R3 cause", 3'd1);
            if (dd == 2) begin
                n = 0;
                while (rst_req) begin @(negedge clk); n++; end
                chk("R8 pulse width", n, 4);
            end
        end

        // R4 service restarts count, config write between keys tolerated
        hard_reset();
        wr(2'd1, cfg_word(1, 3));
        idle(10);
        service();
        measure(n); chk("R4 count from service", n, 16);
        hard_reset();
        wr(2'd1, cfg_word(1, 3));
        idle(5);
        wr(2'd2, K1); wr(2'd1, cfg_word(1, 3)); wr(2'd3, K2);
        measure(n); chk("R4 split sequence", n, 16);

        // R5 bad service variants (disarmed)
        hard_reset();
        wr(2'd2, 32'h1234_5678);
        chk("R5 bad first rst_req", {31'd0, rst_req}, 32'd1);
        expect_cause("R5 bad first cause", 3'd2);
        hard_reset();
        wr(2'd3, K2);
        chk("R5 second without first", {31'd0, rst_req}, 32'd1);
        expect_cause("R5 orphan cause", 3'd2);
        hard_reset();
        wr(2'd2, K1); wr(2'd3, K1);
        chk("R5 bad second rst_req", {31'd0, rst_req}, 32'd1);
        expect_cause("R5 bad second cause", 3'd2);

        // R6 soft reset
        hard_reset();
        wr(2'd0, 32'd2);
        quiet = 1;
        for (int i = 0; i < 6; i++) begin if (rst_req) quiet = 0; @(negedge clk); end
        chk("R6 other value ignored", {31'd0, quiet}, 32'd1);
        expect_cause("R6 cause unchanged", 3'd0);
        wr(2'd0, 32'd1);
        chk("R6 soft rst_req", {31'd0, rst_req}, 32'd1);
        expect_cause("R6 soft cause", 3'd3);

        // R8 writes and user input ignored during pulse
        wr(2'd2, K1);
        user_rst = 1'b1; @(negedge clk); user_rst = 1'b0;
        wait_end();
        expect_cause("R8 user ignored in pulse", 3'd3);
        wr(2'd3, K2);
        expect_cause("R8 key ignored in pulse", 3'd2);
        // R8 config kept, counter restarts
        hard_reset();
        wr(2'd1, cfg_word(1, 2));
        wr(2'd0, 32'd1);
        wait_end();
        measure(n); chk("R8 restart after pulse", n, 8);

        // R7 user reset, R10 cause survives
        hard_reset();
        user_rst = 1'b1; @(negedge clk); user_rst = 1'b0;
        chk("R7 user rst_req", {31'd0, rst_req}, 32'd1);
        expect_cause("R7 user cause", 3'd4);
        wait_end(); idle(20);
        expect_cause("R10 cause persists", 3'd4);
        hard_reset();
        expect_cause("R10 hard reset clears", 3'd0);

        // R9 disable needs service
        hard_reset();
        wr(2'd1, cfg_word(1, 3));
        idle(2);
        wr(2'd1, cfg_word(0, 3));
        measure(n); chk("R9 still counting", n, 13);
        hard_reset();
        wr(2'd1, cfg_word(1, 2));
        wr(2'd1, cfg_word(0, 2));
        service();
        quiet = 1;
        for (int i = 0; i < 40; i++) begin if (rst_req) quiet = 0; @(negedge clk); end
        chk("R9 stopped after service", {31'd0, quiet}, 32'd1);
        wr(2'd1, cfg_word(1, 2));
        measure(n); chk("R9 rearm from zero", n, 8);

        // R11 priorities
        hard_reset();
        wr(2'd1, cfg_word(1, 1));
        idle(3);
        wr(2'd2, 32'hDEAD_0000);
        expect_cause("R11 timeout over bad key", 3'd1);
        hard_reset();
        user_rst = 1'b1; wr(2'd0, 32'd1); user_rst = 1'b0;
        expect_cause("R11 soft over user", 3'd3);
        hard_reset();
        user_rst = 1'b1; wr(2'd3, 32'd7); user_rst = 1'b0;
        expect_cause("R11 bad over user", 3'd2);

        // random: services within window, then a random ending
        for (int it = 0; it < 20; it++) begin
            hard_reset();
            d = $urandom_range(1, 4);
            wr(2'd1, cfg_word(1, d));
            quiet = 1;
            for (int k = 0; k < int'($urandom_range(1, 4)); k++) begin
                g = $urandom_range(0, lim_of(d) - 4);
                for (int i = 0; i < g; i++) begin if (rst_req) quiet = 0; @(negedge clk); end
                service();
                if (rst_req) quiet = 0;
            end
            chk("R4 random services keep quiet", {31'd0, quiet}, 32'd1);
            act = $urandom_range(0, 2);
            if (act == 0) begin
                measure(n); chk("R3 random timeout", n, lim_of(d));
                expect_cause("R3 random cause", 3'd1);
            end else if (act == 1) begin
                v = $urandom();
                if (v == K1) v = v ^ 32'h1;
                wr(2'd2, v);
                chk("R5 random bad key", {31'd0, rst_req}, 32'd1);
                expect_cause("R5 random cause", 3'd2);
            end else begin
                user_rst = 1'b1; @(negedge clk); user_rst = 1'b0;
                chk("R7 random user", {31'd0, rst_req}, 32'd1);
                expect_cause("R7 random cause", 3'd4);
            end
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule